// File: doc/BRIEF.md
# I2C Byte-Memory Target with Persistent Pointer

This block is the target side of a two-wire serial bus, placed in front of a small byte-wide storage array. SCL and SDA arrive already synchronised to the system clock. The block drives SDA only through an open-drain pull-down enable. A controller opens a transaction with a start condition and a device byte. The upper seven bits of that byte must match the `DEV_ADDR` parameter. Its lowest bit selects the direction: 0 for write, 1 for read.

In a write, the controller first sends a 16-bit location, high byte first. Any number of data bytes may follow. Each one lands at the next location. One address pointer is kept across transactions, and it always names the location after the last one accessed. This gives three kinds of read:
- A read that opens directly with the device byte continues from that pointer.
- A random read sends the location in a write phase, then a repeated start with the read bit, with no stop in between.
- Any read keeps streaming consecutive bytes while the controller acknowledges them.

The pointer is `ADDR_W` bits wide and wraps at the top of the array. Location bits above `ADDR_W` are discarded.

The control is a single state machine.

States:
- `S_IDLE`: bus free.
- `S_DEVADDR`: shifting in the device byte.
- `S_DEV_ACK`: acknowledging the device byte.
- `S_ADDR_HI` / `S_HI_ACK`: receiving and acknowledging the high location byte.
- `S_ADDR_LO` / `S_LO_ACK`: receiving and acknowledging the low location byte.
- `S_WDATA` / `S_WR_ACK`: receiving, storing and acknowledging a write byte.
- `S_RDATA`: shifting out a byte.
- `S_RD_ACK`: sampling the controller's acknowledge.
- `S_WAIT`: released, waiting for the next start or stop.

Transitions:
- A stop, from any state, goes to `S_IDLE`.
- A start, from any state, goes to `S_DEVADDR`.
- `S_DEVADDR` goes to `S_DEV_ACK` on a match, otherwise to `S_WAIT`.
- `S_DEV_ACK` goes to `S_RDATA` for a read, otherwise to `S_ADDR_HI`.
- `S_ADDR_HI` → `S_HI_ACK` → `S_ADDR_LO` → `S_LO_ACK` → `S_WDATA` ⇄ `S_WR_ACK`.
- `S_RDATA` → `S_RD_ACK`, which returns to `S_RDATA` on an acknowledge and goes to `S_WAIT` on a not-acknowledge.

Top module: `i2ct_memtarget`

## Requirements
- R1: The target pulls SDA low in the acknowledge slot after a device byte whose upper seven bits equal `DEV_ADDR`. Bit 0 of that byte selects the direction: 0 for write, 1 for read. While SCL stays high, the target never changes its SDA drive.
- R2: After a device byte that does not match, the target leaves SDA released until the next start condition. No byte that follows it changes the memory.
- R3: In a write, the two bytes after the device byte form a 16-bit location, high byte first. Only its low `ADDR_W` bits set the pointer.
- R4: Each data byte that follows in a write is acknowledged and stored at the pointer, and the pointer then advances by one (page write).
- R5: A read that begins directly with the device byte returns the byte at the location after the last one written or read.
- R6: A random read returns the byte at the location sent in the write phase. It is a write phase followed by a repeated start with the read bit and no stop.
- R7: While the controller acknowledges each read byte, the target sends bytes from consecutive locations.
- R8: The pointer wraps from 2^`ADDR_W`−1 to 0, for both writes and reads.
- R9: A not-acknowledge from the controller after a read byte ends output. SDA stays released until a start or stop.
- R10: A stop in the middle of a data byte discards the partial byte without storing it.
- R11: A start in any state clears the bit counter and begins device-byte decoding. A stop in any state returns the target to idle.
- R12: During and after reset, SDA is released and the target is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised bus clock level |
| sda_i | input | 1 | Synchronised bus data level |
| sda_oe_o | output | 1 | Pull SDA low when 1 |

## Verification
The bench builds the target with `ADDR_W` = 6 and `DEV_ADDR` = 0x52. A 64-byte array means a two-byte page write at location 0x3F crosses the wrap within a few bus bytes. That same location, sent as 0xFF7F, also shows that the discarded upper location bits have no effect. The bus clock runs at four system clocks per quarter phase. This leaves room to see the target's one-cycle registered reaction to every SCL edge before the controller model samples it.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
    localparam int BYTE_W = 8;
    localparam int LOC_W  = 16;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DEVADDR,
        S_DEV_ACK,
        S_ADDR_HI,
        S_HI_ACK,
        S_ADDR_LO,
        S_LO_ACK,
        S_WDATA,
        S_WR_ACK,
        S_RDATA,
        S_RD_ACK,
        S_WAIT
    } tstate_e;
endpackage

// File: rtl/i2ct_bus_events.sv
module i2ct_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic start_evt,
    output logic stop_evt,
    output logic scl_rise,
    output logic scl_fall
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    // SDA edges while SCL is held high are bus conditions
    assign start_evt = scl && scl_q && sda_q && !sda;
    assign stop_evt  = scl && scl_q && !sda_q && sda;
    assign scl_rise  = scl && !scl_q;
    assign scl_fall  = !scl && scl_q;
endmodule

// File: rtl/i2ct_mem.sv
module i2ct_mem #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] arr [DEPTH];

    always_ff @(posedge clk) begin
        if (we) arr[addr] <= wdata;
    end

    assign rdata = arr[addr];
endmodule

// File: rtl/i2ct_memtarget.sv
module i2ct_memtarget
    import i2ct_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h50,
    parameter int         ADDR_W   = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe_o
);
    localparam logic [3:0] FULL_CNT = 4'(BYTE_W);
    localparam logic [3:0] LAST_TX  = 4'(BYTE_W - 1);

    tstate_e state, nstate;
    logic start_evt, stop_evt, scl_rise, scl_fall;
    logic [3:0]        cnt;
    logic [BYTE_W-1:0] shreg, txbyte, addr_hi, mem_rdata;
    logic [ADDR_W-1:0] ptr;
    logic              ackd, rx_state, byte_done, mem_we, load_rd, bus_evt;
    logic [LOC_W-1:0]  full_loc;

    i2ct_bus_events u_ev (
        .clk(clk), .rst_n(rst_n), .scl(scl_i), .sda(sda_i),
        .start_evt(start_evt), .stop_evt(stop_evt),
        .scl_rise(scl_rise), .scl_fall(scl_fall)
    );

    i2ct_mem #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_mem (
        .clk(clk), .we(mem_we), .addr(ptr), .wdata(shreg), .rdata(mem_rdata)
    );

    assign bus_evt   = start_evt || stop_evt;
    assign rx_state  = (state == S_DEVADDR) || (state == S_ADDR_HI) ||
                       (state == S_ADDR_LO) || (state == S_WDATA);
    assign byte_done = rx_state && scl_fall && (cnt == FULL_CNT) && !bus_evt;
    assign mem_we    = byte_done && (state == S_WDATA);
    assign load_rd   = scl_fall && !bus_evt &&
                       (((state == S_DEV_ACK) && shreg[0]) || ((state == S_RD_ACK) && ackd));
    assign full_loc  = {addr_hi, shreg};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nstate;
    end

    // next state
    always_comb begin
        nstate = state;
        if (stop_evt) begin
            nstate = S_IDLE;
        end else if (start_evt) begin
            nstate = S_DEVADDR;
        end else begin
            unique case (state)
                S_IDLE:    nstate = S_IDLE;
                S_DEVADDR: if (scl_fall && cnt == FULL_CNT)
                               nstate = (shreg[7:1] == DEV_ADDR) ? S_DEV_ACK : S_WAIT;
                S_DEV_ACK: if (scl_fall) nstate = shreg[0] ? S_RDATA : S_ADDR_HI;
                S_ADDR_HI: if (scl_fall && cnt == FULL_CNT) nstate = S_HI_ACK;
                S_HI_ACK:  if (scl_fall) nstate = S_ADDR_LO;
                S_ADDR_LO: if (scl_fall && cnt == FULL_CNT) nstate = S_LO_ACK;
                S_LO_ACK:  if (scl_fall) nstate = S_WDATA;
                S_WDATA:   if (scl_fall && cnt == FULL_CNT) nstate = S_WR_ACK;
                S_WR_ACK:  if (scl_fall) nstate = S_WDATA;
                S_RDATA:   if (scl_fall && cnt == LAST_TX) nstate = S_RD_ACK;
                S_RD_ACK:  if (scl_fall) nstate = ackd ? S_RDATA : S_WAIT;
                S_WAIT:    nstate = S_WAIT;
                default:   nstate = S_IDLE;
            endcase
        end
    end

    // datapath: bit counter, shifters, pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            shreg   <= '0;
            txbyte  <= '0;
            addr_hi <= '0;
            ackd    <= 1'b0;
            ptr     <= '0;
        end else if (bus_evt) begin
            cnt <= '0;
        end else begin
            if (rx_state && scl_rise && cnt != FULL_CNT) begin
                shreg <= {shreg[BYTE_W-2:0], sda_i};
                cnt   <= cnt + 4'd1;
            end
            if (byte_done) begin
                cnt <= '0;
                if (state == S_ADDR_HI) addr_hi <= shreg;
                if (state == S_ADDR_LO) ptr <= full_loc[ADDR_W-1:0];
                if (state == S_WDATA)   ptr <= ptr + 1'b1;
            end
            if (load_rd) begin
                txbyte <= mem_rdata;
                ptr    <= ptr + 1'b1;
                cnt    <= '0;
            end
            if (state == S_RDATA && scl_fall) begin
                if (cnt == LAST_TX) begin
                    cnt <= '0;
                end else begin
                    txbyte <= {txbyte[BYTE_W-2:0], 1'b0};
                    cnt    <= cnt + 4'd1;
                end
            end
            if (state == S_RD_ACK && scl_rise) ackd <= !sda_i;
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            S_DEV_ACK, S_HI_ACK, S_LO_ACK, S_WR_ACK: sda_oe_o = 1'b1;
            S_RDATA:                                 sda_oe_o = !txbyte[BYTE_W-1];
            default:                                 sda_oe_o = 1'b0;
        endcase
    end

    assert_start_decode_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (start_evt && !stop_evt) |=> (state == S_DEVADDR && cnt == 4'd0));

    assert_stop_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (state == S_IDLE && !sda_oe_o));

    assert_sda_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i) && !$past(start_evt) && !$past(stop_evt)) |-> $stable(sda_oe_o));

    assert_nomatch_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DEVADDR && byte_done && shreg[7:1] != DEV_ADDR) |=>
        (state == S_WAIT && !sda_oe_o));

    assert_data_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> sda_oe_o);

    assert_nack_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RD_ACK && scl_fall && !ackd && !bus_evt) |=> (state == S_WAIT && !sda_oe_o));

    assert_ptr_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && ptr == '1) |=> (ptr == '0));
endmodule

// File: tb/i2ct_memtarget_test.sv
module i2ct_memtarget_test;
    localparam int         CLK_P = 10;
    localparam int         Q     = 4;
    localparam logic [6:0] DEV   = 7'h52;
    localparam int         AW    = 6;
    localparam int         DEPTH = 1 << AW;

    logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, ctl_low = 1'b0;
    logic oe, sda;
    assign sda = !(oe || ctl_low);

    always #(CLK_P/2) clk = ~clk;

    i2ct_memtarget #(.DEV_ADDR(DEV), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .sda_oe_o(oe)
    );

    int checks = 0, errors = 0;
    bit done = 1'b0;
    logic [7:0] model [DEPTH];
    int mptr = 0;
    logic [7:0] exp_q [$];
    string tag_q [$];
    logic [7:0] mon_byte;
    event byte_ev;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic i2c_start();
        ctl_low = 1'b0; wq(); scl = 1'b1; wq(); ctl_low = 1'b1; wq(); scl = 1'b0; wq();
    endtask

    task automatic i2c_stop();
        ctl_low = 1'b1; wq(); scl = 1'b1; wq(); ctl_low = 1'b0; wq();
    endtask

    task automatic send_bit(input bit b);
        ctl_low = !b; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        ctl_low = 1'b0; wq(); scl = 1'b1; wq(); acked = !sda; wq(); scl = 1'b0; wq();
    endtask

    task automatic recv_byte(input bit ack, output logic [7:0] v);
        ctl_low = 1'b0;
        v = '0;
        for (int i = 0; i < 8; i++) begin
            wq(); scl = 1'b1; wq(); v = {v[6:0], sda}; wq(); scl = 1'b0;
        end
        ctl_low = ack; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq(); ctl_low = 1'b0;
    endtask

    // driver side: expected items into the scoreboard
    task automatic expect_next(input string tag);
        exp_q.push_back(model[mptr]);
        tag_q.push_back(tag);
        mptr = (mptr + 1) % DEPTH;
    endtask

    task automatic emit(input logic [7:0] v);
        mon_byte = v;
        -> byte_ev;
        @(negedge clk);
    endtask

    task automatic begin_addr(input logic [7:0] hi, input logic [7:0] lo);
        bit a;
        i2c_start();
        send_byte({DEV, 1'b0}, a); check(a, "R1", "write device ack", a, 1);
        send_byte(hi, a);          check(a, "R3", "high location ack", a, 1);
        send_byte(lo, a);          check(a, "R3", "low location ack", a, 1);
        mptr = {hi, lo} % DEPTH;
    endtask

    task automatic wr_data(input logic [7:0] b);
        bit a;
        send_byte(b, a); check(a, "R4", "data ack", a, 1);
        model[mptr] = b;
        mptr = (mptr + 1) % DEPTH;
    endtask

    task automatic read_bytes(input int n, input string tag, input bit last_ack);
        logic [7:0] v;
        for (int k = 0; k < n; k++) begin
            expect_next(tag);
            recv_byte((k != n - 1) || last_ack, v);
            emit(v);
        end
    endtask

    task automatic rand_read(input logic [7:0] hi, input logic [7:0] lo, input int n,
                             input string tag, input bit do_stop);
        bit a;
        begin_addr(hi, lo);
        i2c_start();
        send_byte({DEV, 1'b1}, a); check(a, "R6", "read device ack after repeated start", a, 1);
        read_bytes(n, tag, 1'b0);
        if (do_stop) i2c_stop();
    endtask

    // monitor: pops expectations as bytes appear on the bus
    initial begin
        forever begin
            @(byte_ev);
            if (exp_q.size() == 0) begin
                check(1'b0, "R7", "unexpected read byte", mon_byte, 0);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(mon_byte === e, t, "read data", mon_byte, e);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        bit a;
        logic [7:0] v;
        repeat (3) @(negedge clk);
        check(oe == 1'b0, "R12", "sda released in reset", oe, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(oe == 1'b0 && sda == 1'b1, "R12", "sda released after reset", oe, 0);

        // R11: aborted device byte, then a repeated start and a page write
        i2c_start();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        begin_addr(8'h00, 8'h10);
        wr_data(8'h11); wr_data(8'h22); wr_data(8'h33); wr_data(8'h44);
        i2c_stop();

        // R6 and R7: random read followed by a sequential byte
        rand_read(8'h00, 8'h10, 2, "R7", 1'b1);

        // R5: current-address read continues after the last byte read
        i2c_start();
        send_byte({DEV, 1'b1}, a); check(a, "R5", "current read device ack", a, 1);
        read_bytes(1, "R5", 1'b0);
        i2c_stop();

        // R3 and R8: high location bits discarded, write wraps to 0
        begin_addr(8'hFF, 8'h7F);
        wr_data(8'hD0); wr_data(8'hD1);
        i2c_stop();
        rand_read(8'h00, 8'h3F, 2, "R8", 1'b1);
        rand_read(8'h00, 8'h00, 1, "R3", 1'b1);

        // R2: other device address is ignored
        i2c_start();
        send_byte({7'h31, 1'b0}, a); check(!a, "R2", "no ack for other device", a, 0);
        send_byte(8'h00, a);         check(!a, "R2", "no ack after mismatch", a, 0);
        send_byte(8'h10, a);         check(!a, "R2", "no ack after mismatch", a, 0);
        send_byte(8'h99, a);         check(!a, "R2", "no ack after mismatch", a, 0);
        i2c_stop();
        rand_read(8'h00, 8'h10, 1, "R2", 1'b1);

        // R9: after a NACK the target leaves the bus alone
        rand_read(8'h00, 8'h11, 1, "R9", 1'b0);
        recv_byte(1'b0, v);
        check(v == 8'hFF, "R9", "bus idle after nack", v, 8'hFF);
        i2c_stop();

        // R10: partial byte before stop is dropped
        begin_addr(8'h00, 8'h20);
        wr_data(8'h00); wr_data(8'h77);
        i2c_stop();
        begin_addr(8'h00, 8'h20);
        wr_data(8'h5A);
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
        i2c_stop();
        rand_read(8'h00, 8'h20, 2, "R10", 1'b1);

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R7", "scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule